// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns segment-relative references of a 16-bit processor into 20-bit physical addresses. It keeps a bank of four 16-bit segment base registers: extra, code, stack and data. Each physical address is the selected base shifted up by four bit positions plus the zero-extended 16-bit offset. Any carry out of bit 19 is dropped, so the 1 MB space wraps around. Each base register on its own spans a 64 KB window. Reaching anything outside that window means loading a new base.

Data and stack requests come in on a valid/ready stream. Each request carries a 2-bit segment select and an offset, and the generated address leaves on a second valid/ready stream. The path is combinational. The output stream is valid exactly when a request is offered, and back-pressure from the consumer shows up directly as `req_ready`. A requester stalled by a low `out_ready` must hold its select and offset. It must also not rewrite the selected base. Under those two conditions the address it sees stays fixed until the transfer completes. A separate fetch output always shows the code base combined with an internal instruction pointer.

Software-side control is plain. There is one write port for the base registers, and a load for the instruction pointer. Both take effect on the next rising clock edge. A readback port shows any base register.

Top module: `segaddr_gen`

## Requirements
- R1: After reset every base register and the instruction pointer are zero, so `fetch_addr` reads 0x00000 and `rd_data` reads 0x0000 for every select.
- R2: A base write (`seg_we`) is visible from the next rising edge. A request, readback or fetch in the same cycle as the write still uses the old value.
- R3: `out_addr` equals (base << 4) + zero-extended `req_off` whenever that sum is below 2^20.
- R4: The select code is 00 for extra, 01 for code, 10 for stack and 11 for data. It is the same on `seg_wsel`, `req_sel` and `rd_sel`, and only the code base (01) feeds `fetch_addr`.
- R5: When the sum reaches 2^20 or more, the carry is dropped and the address wraps modulo 2^20. For example, base 0xFFFF with offset 0x0010 gives 0x00000.
- R6: `fetch_addr` equals (code base << 4) + instruction pointer, modulo 2^20. The pointer loads from `ip_wdata` on the rising edge where `ip_we` is high, and holds otherwise.
- R7: `rd_data` shows, combinationally, the current base register chosen by `rd_sel`.
- R8: `out_valid` follows `req_valid` and `req_ready` follows `out_ready` in the same cycle. While a request stalls with its inputs held and no base write, `out_addr` does not change.
- R9: A write changes only the register addressed by `seg_wsel`. Every other base register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_we | input | 1 | Base register write enable |
| seg_wsel | input | 2 | Base register to write (R4 encoding) |
| seg_wdata | input | 16 | Value to write |
| ip_we | input | 1 | Instruction pointer load enable |
| ip_wdata | input | 16 | Instruction pointer load value |
| req_valid | input | 1 | Address request offered |
| req_ready | output | 1 | Request accepted this cycle |
| req_sel | input | 2 | Segment select of the request |
| req_off | input | 16 | Offset of the request |
| out_valid | output | 1 | Generated address available |
| out_ready | input | 1 | Consumer takes the address |
| out_addr | output | 20 | Generated physical address |
| fetch_addr | output | 20 | Instruction fetch address |
| rd_sel | input | 2 | Base register to read back |
| rd_data | output | 16 | Read-back base value |

## Verification
The stall-stability property assumes two things about a stalled request: the requester keeps `req_sel` and `req_off` unchanged, and it issues no base write while the stall lasts. The property only fires when both conditions hold. In its directed back-pressure phase the stimulus holds these inputs fixed with writes disabled. In the random phase, back-pressure and input changes mix freely, and the guard on the property keeps those cycles outside its claim. The readback and fetch-hold properties assume nothing beyond the write and load enables seen on the previous edge.

// File: rtl/segaddr_pkg.sv
package segaddr_pkg;
  localparam int SEG_W   = 16;
  localparam int OFF_W   = 16;
  localparam int SHIFT   = 4;
  localparam int PA_W    = SEG_W + SHIFT;
  localparam int SEL_W   = 2;
  localparam int NUM_SEG = 1 << SEL_W;

  typedef enum logic [SEL_W-1:0] {
    SEG_EXTRA = 2'b00,
    SEG_CODE  = 2'b01,
    SEG_STACK = 2'b10,
    SEG_DATA  = 2'b11
  } seg_sel_e;
endpackage

// File: rtl/segaddr_bank.sv
module segaddr_bank #(
  parameter int SEG_W    = 16,
  parameter int SEL_W    = 2,
  parameter int CODE_SEL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  input  logic [SEL_W-1:0] req_sel,
  output logic [SEG_W-1:0] req_base,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [SEG_W-1:0] rd_base,
  output logic [SEG_W-1:0] code_base
);
  localparam int NUM = 1 << SEL_W;

  logic [SEG_W-1:0] base_q [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_sel == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   base_q[g] <= '0;
      else if (hit) base_q[g] <= wr_data;
    end
  end

  assign req_base  = base_q[req_sel];
  assign rd_base   = base_q[rd_sel];
  assign code_base = base_q[CODE_SEL];
endmodule

// File: rtl/segaddr_ipreg.sv
module segaddr_ipreg #(
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFF_W-1:0] load_val,
  output logic [OFF_W-1:0] ip
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ip <= '0;
    else if (load) ip <= load_val;
  end
endmodule

// File: rtl/segaddr_calc.sv
module segaddr_calc #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4
) (
  input  logic [SEG_W-1:0]       seg,
  input  logic [OFF_W-1:0]       off,
  output logic [SEG_W+SHIFT-1:0] addr
);
  localparam int PA_W = SEG_W + SHIFT;

  logic [PA_W-1:0] base_ext;
  logic [PA_W-1:0] off_ext;

  assign base_ext = {seg, {SHIFT{1'b0}}};
  assign off_ext  = PA_W'(off);
  // Same-width sum: the carry beyond the top bit is dropped, giving wraparound.
  assign addr     = base_ext + off_ext;
endmodule

// File: rtl/segaddr_gen.sv
module segaddr_gen
  import segaddr_pkg::*;
#(
  parameter int P_SEG_W = SEG_W,
  parameter int P_OFF_W = OFF_W,
  parameter int P_SHIFT = SHIFT,
  parameter int P_SEL_W = SEL_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       seg_we,
  input  logic [P_SEL_W-1:0]         seg_wsel,
  input  logic [P_SEG_W-1:0]         seg_wdata,
  input  logic                       ip_we,
  input  logic [P_OFF_W-1:0]         ip_wdata,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [P_SEL_W-1:0]         req_sel,
  input  logic [P_OFF_W-1:0]         req_off,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [P_SEG_W+P_SHIFT-1:0] out_addr,
  output logic [P_SEG_W+P_SHIFT-1:0] fetch_addr,
  input  logic [P_SEL_W-1:0]         rd_sel,
  output logic [P_SEG_W-1:0]         rd_data
);
  localparam int CODE_IDX = int'(SEG_CODE);

  logic [P_SEG_W-1:0] req_base;
  logic [P_SEG_W-1:0] code_base;
  logic [P_OFF_W-1:0] ip_q;

  segaddr_bank #(
    .SEG_W(P_SEG_W), .SEL_W(P_SEL_W), .CODE_SEL(CODE_IDX)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(seg_we), .wr_sel(seg_wsel), .wr_data(seg_wdata),
    .req_sel(req_sel), .req_base(req_base),
    .rd_sel(rd_sel), .rd_base(rd_data),
    .code_base(code_base)
  );

  segaddr_ipreg #(.OFF_W(P_OFF_W)) u_ip (
    .clk(clk), .rst_n(rst_n), .load(ip_we), .load_val(ip_wdata), .ip(ip_q)
  );

  segaddr_calc #(.SEG_W(P_SEG_W), .OFF_W(P_OFF_W), .SHIFT(P_SHIFT)) u_data_calc (
    .seg(req_base), .off(req_off), .addr(out_addr)
  );

  segaddr_calc #(.SEG_W(P_SEG_W), .OFF_W(P_OFF_W), .SHIFT(P_SHIFT)) u_fetch_calc (
    .seg(code_base), .off(ip_q), .addr(fetch_addr)
  );

  // Pass-through stream: no storage, so back-pressure flows straight upstream.
  assign out_valid = req_valid;
  assign req_ready = out_ready;
endmodule

// File: rtl/segaddr_gen_chk.sv
module segaddr_gen_chk
  import segaddr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             seg_we,
  input logic [SEL_W-1:0] seg_wsel,
  input logic [SEG_W-1:0] seg_wdata,
  input logic             ip_we,
  input logic [SEL_W-1:0] req_sel,
  input logic [OFF_W-1:0] req_off,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PA_W-1:0]  out_addr,
  input logic [PA_W-1:0]  fetch_addr,
  input logic [SEL_W-1:0] rd_sel,
  input logic [SEG_W-1:0] rd_data
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1: first cycle out of reset shows zeroed state
  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !past_ok |-> (fetch_addr == '0 && rd_data == '0));

  // R2: a written value appears on readback from the next edge
  assert_write_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(seg_we) && (rd_sel == $past(seg_wsel)) |-> rd_data == $past(seg_wdata));

  // R9: without a write, a held readback select sees a held value
  assert_hold_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(!seg_we) && $stable(rd_sel) |-> $stable(rd_data));

  // R6: fetch address moves only after a base write or pointer load
  assert_fetch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(!seg_we && !ip_we) |-> $stable(fetch_addr));

  // R8: a stalled request with held inputs keeps its address
  assert_stall_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(out_valid && !out_ready && !seg_we) && out_valid
      && $stable(req_sel) && $stable(req_off) |-> $stable(out_addr));
endmodule

bind segaddr_gen segaddr_gen_chk u_chk (.*);

// File: tb/segaddr_gen_bench.sv
module segaddr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_we = 1'b0;
  logic [1:0]  seg_wsel = '0;
  logic [15:0] seg_wdata = '0;
  logic        ip_we = 1'b0;
  logic [15:0] ip_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_sel = '0;
  logic [15:0] req_off = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [19:0] out_addr;
  logic [19:0] fetch_addr;
  logic [1:0]  rd_sel = '0;
  logic [15:0] rd_data;

  int vectors = 0;
  int errors  = 0;
  int m_seg [4];
  int m_ip = 0;
  string addr_tag = "R3";
  string rd_tag   = "R7";

  always #4 clk = ~clk;

  segaddr_gen u_segaddr_gen (.*);

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%05h expected=0x%05h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int phys(int s, int o);
    return ((s << 4) + o) % 1048576;
  endfunction

  // Inputs set at negedge; compare mid-cycle; update model on the edge.
  task automatic cycle();
    int s;
    #1;
    s = m_seg[req_sel];
    chk("R8", int'(out_valid), int'(req_valid));
    chk("R8", int'(req_ready), int'(out_ready));
    chk(((s << 4) + int'(req_off)) >= 1048576 ? "R5" : addr_tag,
        int'(out_addr), phys(s, int'(req_off)));
    chk("R6", int'(fetch_addr), phys(m_seg[1], m_ip));
    chk(rd_tag, int'(rd_data), m_seg[rd_sel]);
    @(posedge clk);
    if (seg_we) m_seg[seg_wsel] = int'(seg_wdata);
    if (ip_we)  m_ip = int'(ip_wdata);
    @(negedge clk);
  endtask

  task automatic wr_seg(int sel, int val);
    seg_we = 1'b1; seg_wsel = 2'(sel); seg_wdata = 16'(val);
    cycle();
    seg_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) m_seg[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      rd_sel = 2'(i);
      #1;
      chk("R1", int'(rd_data), 0);
    end
    chk("R1", int'(fetch_addr), 0);
    @(negedge clk);

    // R4: select 01 is the code base feeding fetch
    wr_seg(1, 16'h1234);
    #1; chk("R4", int'(fetch_addr), 32'h12340);
    @(negedge clk);
    wr_seg(0, 16'hA001);
    wr_seg(2, 16'h3C00);
    wr_seg(3, 16'h2B8C);
    #1; chk("R4", int'(fetch_addr), 32'h12340);
    @(negedge clk);

    // R6: pointer load
    ip_we = 1'b1; ip_wdata = 16'h15FE;
    cycle();
    ip_we = 1'b0;
    #1; chk("R6", int'(fetch_addr), 32'h1393E);
    @(negedge clk);

    // R3: directed addresses on each select
    req_valid = 1'b1;
    req_sel = 2'd3; req_off = 16'h8D21; cycle();
    #1; chk("R3", int'(out_addr), 32'h345E1);
    @(negedge clk);
    req_sel = 2'd2; req_off = 16'h0000; cycle();
    req_sel = 2'd0; req_off = 16'h7A04; cycle();

    // R5: wraparound at the top of the space
    wr_seg(3, 16'hFFFF);
    req_sel = 2'd3; req_off = 16'h0010;
    #1; chk("R5", int'(out_addr), 0);
    @(negedge clk);
    req_off = 16'hFFFF;
    #1; chk("R5", int'(out_addr), 32'h0FFEF);
    @(negedge clk);
    req_off = 16'h000F;
    #1; chk("R5", int'(out_addr), 32'hFFFFF);
    @(negedge clk);

    // R2: write and request in the same cycle sees the old base
    addr_tag = "R2"; rd_tag = "R2";
    req_sel = 2'd2; rd_sel = 2'd2; req_off = 16'h0004;
    seg_we = 1'b1; seg_wsel = 2'd2; seg_wdata = 16'h0100;
    #1; chk("R2", int'(out_addr), 32'h3C004);
    cycle();
    seg_we = 1'b0;
    #1; chk("R2", int'(out_addr), 32'h01004);
    chk("R2", int'(rd_data), 32'h0100);
    @(negedge clk);
    addr_tag = "R3"; rd_tag = "R7";

    // R9: writing one base leaves the others alone
    wr_seg(0, 16'h5555);
    rd_tag = "R9";
    for (int i = 0; i < 4; i++) begin
      rd_sel = 2'(i);
      cycle();
    end
    rd_tag = "R7";

    // R8: back-pressure with held inputs
    req_sel = 2'd1; req_off = 16'hBEEF; out_ready = 1'b0;
    addr_tag = "R8";
    for (int i = 0; i < 5; i++) begin
      #1;
      chk("R8", int'(req_ready), 0);
      chk("R8", int'(out_addr), phys(32'h1234, 32'hBEEF));
      @(negedge clk);
    end
    out_ready = 1'b1;
    cycle();
    req_valid = 1'b0;
    cycle();
    addr_tag = "R3";

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      seg_we    = ($urandom % 4) == 0;
      seg_wsel  = 2'($urandom);
      seg_wdata = ($urandom % 8 == 0) ? 16'hFFFF : 16'($urandom);
      ip_we     = ($urandom % 6) == 0;
      ip_wdata  = 16'($urandom);
      req_valid = 1'($urandom);
      out_ready = 1'($urandom);
      req_sel   = 2'($urandom);
      req_off   = ($urandom % 8 == 0) ? 16'hFFFF : 16'($urandom);
      rd_sel    = 2'($urandom);
      cycle();
    end
    seg_we = 1'b0; ip_we = 1'b0;
    cycle();
    finish_run();
  end
endmodule